// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port behind a simple single-cycle register bus. It keeps a direction register and an output latch. It drives pad outputs and per-pin output enables, and it brings pad inputs into the clock domain through a two-stage synchronizer. Software reaches the pin data through a window of addresses. In that window the word address itself carries a per-pin mask, so a driver can set or clear any subset of pins in a single write without first reading the register.

A bus access is presented for exactly one cycle on `bus_valid`, with `bus_write` selecting the direction. Write effects appear on the pads at the clock edge that samples the access. Read data is registered and presented on `bus_rdata` in the cycle after the request. `bus_rdata` then holds until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input and the output latch is zero: `pad_oe` = 0, `pad_out` = 0, `bus_rdata` = 0, and a read of the direction register returns 0.
- R2: A write to byte offset 0x400 loads the direction register, where bit n = 1 makes pin n an output. `pad_oe` follows that register from the next clock edge, and a read of 0x400 returns it.
- R3: A write to a word-aligned offset in 0x000–0x3FC updates output-latch bit n only when address bit n+2 is 1 and pin n is an output. Every other latch bit keeps its value.
- R4: A data write leaves the latch bit of an input pin unchanged. When that pin is later switched to output, it drives its previous latch value until it is written again.
- R5: A data read returns 0 in every bit position whose address mask bit (address bit n+2) is 0.
- R6: In a masked-in position, a data read returns the latch bit for an output pin and the synchronized pad level for an input pin.
- R7: A pad change applied just before clock edge k is first seen by a read sampled at edge k+2. Reads sampled at edges k and k+1 still return the old level.
- R8: Offsets that are misaligned (address bits [1:0] not zero) or that lie outside 0x000–0x3FC and 0x400 read as 0. Writes to them change neither the direction register nor the output latch.
- R9: `bus_rdata` changes only in the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Registered read data, valid the cycle after a read |
| pad_in | input | NPIN | Asynchronous pad input levels |
| pad_out | output | NPIN | Output latch driven to the pads |
| pad_oe | output | NPIN | Per-pin output enable (the direction register) |

## Verification
Write effects on `pad_out` and `pad_oe` are due at the edge that samples the write, so the bench checks them at the following falling edge. Read data is due one edge after the request. The monitor therefore pops the expected value at the falling edge that follows the edge where a read was sampled, and this works for back-to-back reads as well. Synchronizer latency is checked with three consecutive reads started in the same cycle as a pad change. The expected values are old, old, new, which pins down the two-stage depth exactly.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Kind of register an access lands on
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_mask_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc,
    output logic [NPIN-1:0]   pin_mask
);
    // Data window spans offsets whose bits above the mask field are zero
    localparam int MASK_LO = 2;
    localparam int MASK_HI = NPIN + MASK_LO - 1;
    localparam int DIR_OFS = 1 << (NPIN + MASK_LO);

    logic aligned;
    logic upper_zero;

    assign aligned    = (addr[MASK_LO-1:0] == '0);
    assign upper_zero = (addr[ADDR_W-1:MASK_HI+1] == '0);
    assign pin_mask   = addr[MASK_HI:MASK_LO];

    always_comb begin
        acc = ACC_NONE;
        if (aligned && upper_zero) begin
            acc = ACC_DATA;
        end else if (addr == ADDR_W'(DIR_OFS)) begin
            acc = ACC_DIR;
        end
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_sync
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= pad_in[i];
                stab_q <= meta_q;
            end
        end

        assign pad_sync[i] = stab_q;
    end
endmodule

// File: rtl/gpio_pin_view.sv
module gpio_pin_view #(
    parameter int NPIN = 8
) (
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] latch,
    input  logic [NPIN-1:0] pad_sync,
    output logic [NPIN-1:0] level
);
    // Per pin: outputs show the latch, inputs show the synchronized pad
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign level[i] = dir[i] ? latch[i] : pad_sync[i];
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe
);
    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] latch;
        logic [NPIN-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    acc_e            acc;
    logic [NPIN-1:0] pin_mask;
    logic [NPIN-1:0] pad_sync;
    logic [NPIN-1:0] level;

    gpio_addr_dec #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .acc      (acc),
        .pin_mask (pin_mask)
    );

    gpio_sync2 #(.NPIN(NPIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_sync (pad_sync)
    );

    gpio_pin_view #(.NPIN(NPIN)) u_view (
        .dir      (st_q.dir),
        .latch    (st_q.latch),
        .pad_sync (pad_sync),
        .level    (level)
    );

    always_comb begin
        logic [NPIN-1:0] wr_en;
        st_d  = st_q;
        wr_en = pin_mask & st_q.dir;
        if (bus_valid && bus_write) begin
            unique case (acc)
                ACC_DATA: st_d.latch = (st_q.latch & ~wr_en) | (bus_wdata & wr_en);
                ACC_DIR:  st_d.dir   = bus_wdata;
                default:  ;
            endcase
        end
        if (bus_valid && !bus_write) begin
            unique case (acc)
                ACC_DATA: st_d.rdata = level & pin_mask;
                ACC_DIR:  st_d.rdata = st_q.dir;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.latch;
    assign pad_oe    = st_q.dir;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPIN-1:0]   bus_wdata,
    input logic [NPIN-1:0]   bus_rdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe
);
    localparam int DIR_OFS = 1 << (NPIN + 2);

    logic            in_win;
    logic            at_dir;
    logic [NPIN-1:0] amask;

    assign in_win = (bus_addr[ADDR_W-1:NPIN+2] == '0) && (bus_addr[1:0] == 2'b00);
    assign at_dir = (bus_addr == ADDR_W'(DIR_OFS));
    assign amask  = bus_addr[NPIN+1:2];

    // R2: direction write reaches the output enables
    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && at_dir |=> pad_oe == $past(bus_wdata));

    // R3/R4: latch bits outside mask-and-output stay put
    assert_latch_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && in_win |=>
            ((pad_out ^ $past(pad_out)) & ~($past(amask) & $past(pad_oe))) == '0);

    // R5: masked-out read positions are zero
    assert_read_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && in_win |=> (bus_rdata & ~$past(amask)) == '0);

    // R6: output pins read back the latch
    assert_out_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && in_win |=>
            (bus_rdata & $past(amask & pad_oe)) == $past(pad_out & amask & pad_oe));

    // R8: unmapped accesses
    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && !in_win && !at_dir |=> bus_rdata == '0);
    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && !in_win && !at_dir |=> $stable(pad_out) && $stable(pad_oe));

    // R9: read data holds without a read
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
    localparam int NPIN   = 8;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [NPIN-1:0]   bus_wdata = '0;
    logic [NPIN-1:0]   bus_rdata;
    logic [NPIN-1:0]   pad_in = '0;
    logic [NPIN-1:0]   pad_out;
    logic [NPIN-1:0]   pad_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NPIN-1:0] exp_q[$];
    string           tag_q[$];
    logic            rd_pend = 1'b0;

    always #4 clk = ~clk;

    gpio_mask_port #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string req, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: one expected item per read sampled at the last edge
    always @(posedge clk) rd_pend <= rst_n && bus_valid && !bus_write;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard actual %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            bus_valid = 1'b0;
            bus_write = 1'b0;
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [NPIN-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    // Leaves the request up; caller chains reads or idles
    task automatic rd(logic [ADDR_W-1:0] a, logic [NPIN-1:0] exp, string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rd(12'h400, 8'h00, "R1 dir read"); idle(2);

        wr(12'h400, 8'h0F); idle(1);
        check("R2 pad_oe", pad_oe, 8'h0F);
        rd(12'h400, 8'h0F, "R2 dir read"); idle(2);

        wr(12'h3FC, 8'hFF); idle(1);
        check("R4 input pins untouched", pad_out, 8'h0F);

        wr(12'h014, 8'h00); idle(1);
        check("R3 masked write", pad_out, 8'h0A);

        pad_in = 8'hA5; idle(4);
        rd(12'h3FC, 8'hAA, "R6 mixed read");
        rd(12'h0C0, 8'h20, "R5 masked read");
        rd(12'h00C, 8'h02, "R5 low mask read"); idle(2);
        check("R9 rdata holds", bus_rdata, 8'h02);

        wr(12'h400, 8'hFF); idle(1);
        check("R4 latch kept", pad_out, 8'h0A);
        rd(12'h3FC, 8'h0A, "R6 output readback"); idle(2);

        wr(12'h3FC, 8'hF0); idle(1);
        check("R3 full write", pad_out, 8'hF0);
        wr(12'h200, 8'h0F); idle(1);
        check("R3 single pin write", pad_out, 8'h70);

        wr(12'h404, 8'h00);
        wr(12'h3FD, 8'hFF);
        wr(12'h800, 8'h00); idle(1);
        check("R8 write oe", pad_oe, 8'hFF);
        check("R8 write out", pad_out, 8'h70);
        rd(12'h800, 8'h00, "R8 far read");
        rd(12'h3FE, 8'h00, "R8 misaligned read");
        rd(12'h408, 8'h00, "R8 gap read"); idle(2);

        wr(12'h400, 8'h00); idle(4);
        rd(12'h3FC, 8'hA5, "R7 before change"); idle(1);
        @(negedge clk);
        pad_in = 8'h3C;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h3FC;
        exp_q.push_back(8'hA5); tag_q.push_back("R7 edge k");
        rd(12'h3FC, 8'hA5, "R7 edge k+1");
        rd(12'h3FC, 8'h3C, "R7 edge k+2"); idle(3);

        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard actual %0d expected 0 left", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule